// File: doc/BRIEF.md
# 64-bit SECDED Read/Write Path Guard

This block protects 64-bit words held in an external storage array. It uses an extended Hamming code with single-error correction and double-error detection. On the write side a combinational encoder turns each data word into a 72-bit codeword. On the read side a one-stage registered decoder takes a 72-bit word and the address it was fetched from. It returns the data, corrected when one bit is wrong, and raises a flag that classifies the result.

Correction is applied only to what leaves the decoder. The block holds no storage and never writes a repaired word back, so a faulty stored word stays faulty and is flagged again on every read. A small log keeps the address of the first faulty word seen after it was last cleared. Two test controls let a bench or a self-test routine corrupt one or two chosen bits of a codeword while it is being encoded. This exercises both error paths without touching the array.

Top module: `secded_guard`

## Requirements
- R1: Codeword bit index 0 is an overall parity bit that makes the XOR of all 72 bits zero. Indices 1, 2, 4, 8, 16, 32 and 64 are check bits. The 64 data bits fill the remaining indices 3..71 in ascending order, data bit 0 first. The check bit at index 2^j is the XOR of every other bit in indices 1..71 whose index has bit j set. `enc_word` shows this codeword combinationally whenever no injection is active.
- R2: When a read word differs from a valid codeword in exactly one bit, at any index 0..71, `dec_data` returns the original 64 data bits, `err_single` is 1 and `err_double` is 0.
- R3: The decoder never alters the word held in storage. The same faulty word read again is corrected and flagged single again.
- R4: When a read word differs from a valid codeword in exactly two bits, `err_double` is 1 and `err_single` is 0. `dec_data` carries the data bits of the received word without any change.
- R5: A single error at a check-bit or parity index (0, 1, 2, 4, ..., 64) sets `err_single` and leaves `dec_data` equal to the stored data bits.
- R6: With `inj_single` at 1, `enc_word` is the R1 codeword with the bit at index `inj_pos_a` inverted. With `inj_double` at 1, the bits at `inj_pos_a` and `inj_pos_b` are both inverted. A position of 72 or more inverts nothing. `inj_double` takes precedence over `inj_single`.
- R7: `dec_valid`, `dec_data`, `err_single` and `err_double` update on the clock edge that samples `rd_valid` high, so they are valid one cycle later. In a cycle after one with `rd_valid` low, `dec_valid` and both flags are 0 and `dec_data` holds its last value.
- R8: The first read that raises either flag while `err_addr_valid` is 0 loads its `rd_addr` into `err_addr` and sets `err_addr_valid`, on the same edge as the flags. Later errors leave `err_addr` unchanged until it is cleared.
- R9: `err_clr` at 1 drops `err_addr_valid` on the next edge. If a flagged read arrives in that same cycle, that read's address is captured instead and `err_addr_valid` stays 1.
- R10: Synchronous reset sets `dec_valid`, `dec_data`, both flags, `err_addr_valid` and `err_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data | input | 64 | Data word to encode |
| inj_single | input | 1 | Invert the codeword bit at inj_pos_a |
| inj_double | input | 1 | Invert the codeword bits at inj_pos_a and inj_pos_b |
| inj_pos_a | input | 7 | First injection index (0..71) |
| inj_pos_b | input | 7 | Second injection index (0..71) |
| enc_word | output | 72 | Encoded codeword, optionally corrupted |
| rd_valid | input | 1 | A read word is presented this cycle |
| rd_word | input | 72 | Codeword read from storage |
| rd_addr | input | ADDR_W | Address of the read word |
| err_clr | input | 1 | Clear the error address log |
| dec_valid | output | 1 | Decoded result valid |
| dec_data | output | 64 | Corrected (or, on a double error, raw) data |
| err_single | output | 1 | A single error was found and corrected |
| err_double | output | 1 | A double error was found |
| err_addr_valid | output | 1 | The error address log holds an address |
| err_addr | output | ADDR_W | Address of the first logged faulty word |

## Verification
A wrong syndrome-to-index mapping shows up as a wrong `dec_data` or a wrong flag one cycle after the read. The bench therefore inverts each of the 72 indices in turn and then tries double-error pairs that mix data, check and parity indices. A log that re-arms early or fails to hold is visible in `err_addr` on the edge of the second faulty read. An encoder placement error appears at once on `enc_word`, which the bench compares with a codeword it builds itself.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int CW_W   = 72;
    localparam int SYN_W  = 7;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef struct packed {
        logic  one_bad;
        logic  two_bad;
        syn_t  syn;
    } diag_t;

    function automatic logic is_pow2(int i);
        return (i & (i - 1)) == 0;
    endfunction

    function automatic cw_t spread_data(data_t d);
        cw_t cw;
        int  k;
        cw = '0;
        k  = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                cw[i] = d[k];
                k++;
            end
        end
        return cw;
    endfunction

    function automatic data_t gather_data(cw_t cw);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int i = 1; i < CW_W; i++) begin
            if (!is_pow2(i)) begin
                d[k] = cw[i];
                k++;
            end
        end
        return d;
    endfunction

    function automatic syn_t index_xor(cw_t cw);
        syn_t s;
        s = '0;
        for (int i = 1; i < CW_W; i++) begin
            if (cw[i]) s ^= syn_t'(i);
        end
        return s;
    endfunction

    function automatic cw_t build_cw(data_t d);
        cw_t  cw;
        syn_t s;
        cw = spread_data(d);
        s  = index_xor(cw);
        for (int j = 0; j < SYN_W; j++) begin
            cw[2**j] = s[j];
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic diag_t classify(cw_t cw);
        diag_t r;
        logic  odd;
        r.syn     = index_xor(cw);
        odd       = ^cw;
        r.one_bad = odd && (int'(r.syn) < CW_W);
        r.two_bad = (!odd && (r.syn != '0)) || (odd && (int'(r.syn) >= CW_W));
        return r;
    endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  data_t      data_in,
    input  logic       flip_one,
    input  logic       flip_two,
    input  syn_t       pos_a,
    input  syn_t       pos_b,
    output cw_t        cw_out
);
    cw_t clean;
    cw_t mask_a;
    cw_t mask_b;
    cw_t mask;

    always_comb begin
        clean  = build_cw(data_in);
        mask_a = cw_t'(1) << pos_a;
        mask_b = cw_t'(1) << pos_b;
        if (flip_two)      mask = mask_a ^ mask_b;
        else if (flip_one) mask = mask_a;
        else               mask = '0;
        cw_out = clean ^ mask;
    end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import secded_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  cw_t    in_word,
    output logic   hit_now,
    output logic   out_valid,
    output data_t  out_data,
    output logic   out_single,
    output logic   out_double
);
    diag_t dg;
    cw_t   fixed;

    always_comb begin
        dg = classify(in_word);
        if (dg.one_bad) fixed = in_word ^ (cw_t'(1) << dg.syn);
        else            fixed = in_word;
        hit_now = in_valid && (dg.one_bad || dg.two_bad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_single <= 1'b0;
            out_double <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_single <= in_valid && dg.one_bad;
            out_double <= in_valid && dg.two_bad;
            if (in_valid) out_data <= gather_data(fixed);
        end
    end
endmodule

// File: rtl/secded_err_log.sv
module secded_err_log #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              clr,
    output logic              held,
    output logic [ADDR_W-1:0] held_addr
);
    logic armed;

    assign armed = !held || clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_addr <= '0;
        end else if (hit && armed) begin
            held      <= 1'b1;
            held_addr <= hit_addr;
        end else if (clr) begin
            held      <= 1'b0;
        end
    end
endmodule

// File: rtl/secded_guard.sv
module secded_guard
    import secded_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       enc_data,
    input  logic              inj_single,
    input  logic              inj_double,
    input  logic [6:0]        inj_pos_a,
    input  logic [6:0]        inj_pos_b,
    output logic [71:0]       enc_word,
    input  logic              rd_valid,
    input  logic [71:0]       rd_word,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              err_clr,
    output logic              dec_valid,
    output logic [63:0]       dec_data,
    output logic              err_single,
    output logic              err_double,
    output logic              err_addr_valid,
    output logic [ADDR_W-1:0] err_addr
);
    logic hit_now;

    secded_encoder u_enc (
        .data_in  (enc_data),
        .flip_one (inj_single),
        .flip_two (inj_double),
        .pos_a    (inj_pos_a),
        .pos_b    (inj_pos_b),
        .cw_out   (enc_word)
    );

    secded_decoder u_dec (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rd_valid),
        .in_word    (rd_word),
        .hit_now    (hit_now),
        .out_valid  (dec_valid),
        .out_data   (dec_data),
        .out_single (err_single),
        .out_double (err_double)
    );

    secded_err_log #(.ADDR_W(ADDR_W)) u_log (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit_now),
        .hit_addr  (rd_addr),
        .clr       (err_clr),
        .held      (err_addr_valid),
        .held_addr (err_addr)
    );
endmodule

// File: rtl/secded_guard_chk.sv
module secded_guard_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [63:0]       enc_data,
    input logic              inj_single,
    input logic              inj_double,
    input logic [71:0]       enc_word,
    input logic              rd_valid,
    input logic [71:0]       rd_word,
    input logic              err_clr,
    input logic              dec_valid,
    input logic [63:0]       dec_data,
    input logic              err_single,
    input logic              err_double,
    input logic              err_addr_valid,
    input logic [ADDR_W-1:0] err_addr
);
    // R4: a result is never both single and double
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(err_single && err_double));

    // R7: flags only accompany a valid result
    a_r7_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        (err_single || err_double) |-> dec_valid);

    // R7: one-cycle latency
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> dec_valid);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (!dec_valid && !err_single && !err_double));

    // R1: clean encoder output looped back decodes to the same data, no flags
    a_r1_round_trip: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !inj_single && !inj_double && rd_word == enc_word)
        |=> (!err_single && !err_double && dec_data == $past(enc_data)));

    // R8: a held address stays put until cleared
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (err_addr_valid && !err_clr) |=> (err_addr_valid && $stable(err_addr)));

    // R8: the log only arms together with a flagged result
    a_r8_capture_with_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(err_addr_valid) |-> (err_single || err_double));

    // R9: a clear with no read empties the log
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !rd_valid) |=> !err_addr_valid);

    // R10: reset state
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!dec_valid && !err_single && !err_double && !err_addr_valid
                 && err_addr == '0 && dec_data == '0));
endmodule

bind secded_guard secded_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .enc_data       (enc_data),
    .inj_single     (inj_single),
    .inj_double     (inj_double),
    .enc_word       (enc_word),
    .rd_valid       (rd_valid),
    .rd_word        (rd_word),
    .err_clr        (err_clr),
    .dec_valid      (dec_valid),
    .dec_data       (dec_data),
    .err_single     (err_single),
    .err_double     (err_double),
    .err_addr_valid (err_addr_valid),
    .err_addr       (err_addr)
);

// File: tb/test_secded_guard.sv
`timescale 1ns/1ps
module test_secded_guard;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [63:0]   enc_data = '0;
    logic          inj_single = 1'b0;
    logic          inj_double = 1'b0;
    logic [6:0]    inj_pos_a = '0;
    logic [6:0]    inj_pos_b = '0;
    logic [71:0]   enc_word;
    logic          rd_valid = 1'b0;
    logic [71:0]   rd_word = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          err_clr = 1'b0;
    logic          dec_valid;
    logic [63:0]   dec_data;
    logic          err_single;
    logic          err_double;
    logic          err_addr_valid;
    logic [AW-1:0] err_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    secded_guard #(.ADDR_W(AW)) i_secded_guard (
        .clk(clk), .rst(rst), .enc_data(enc_data), .inj_single(inj_single),
        .inj_double(inj_double), .inj_pos_a(inj_pos_a), .inj_pos_b(inj_pos_b),
        .enc_word(enc_word), .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_addr(rd_addr), .err_clr(err_clr), .dec_valid(dec_valid),
        .dec_data(dec_data), .err_single(err_single), .err_double(err_double),
        .err_addr_valid(err_addr_valid), .err_addr(err_addr)
    );

    // Reference codeword built from the R1 wording: data placement, then
    // each check bit from the indices that carry its bit, then parity.
    function automatic logic [71:0] ref_cw(logic [63:0] d);
        logic [71:0] w;
        int k;
        logic p;
        w = '0;
        k = 0;
        for (int i = 1; i < 72; i++) begin
            if (i != 1 && i != 2 && i != 4 && i != 8 && i != 16 && i != 32 && i != 64) begin
                w[i] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 7; j++) begin
            p = 1'b0;
            for (int i = 1; i < 72; i++) begin
                if (i != (1 << j) && ((i >> j) & 1) == 1) p ^= w[i];
            end
            w[1 << j] = p;
        end
        w[0] = ^w[71:1];
        return w;
    endfunction

    function automatic logic [63:0] ref_data(logic [71:0] w);
        logic [63:0] d;
        int k;
        d = '0;
        k = 0;
        for (int i = 1; i < 72; i++) begin
            if (i != 1 && i != 2 && i != 4 && i != 8 && i != 16 && i != 32 && i != 64) begin
                d[k] = w[i];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [71:0] bit_at(int p);
        return (p < 72) ? (72'd1 << p) : 72'd0;
    endfunction

    task automatic check(string req, logic [71:0] act, logic [71:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read: present word at a negedge, sample after the next posedge.
    task automatic do_read(logic [71:0] w, logic [AW-1:0] a, logic clr);
        @(negedge clk);
        rd_word  = w;
        rd_addr  = a;
        rd_valid = 1'b1;
        err_clr  = clr;
        @(negedge clk);
        rd_valid = 1'b0;
        err_clr  = 1'b0;
    endtask

    // {data, mode (0 none, 1 single, 2 double), pos_a, pos_b}
    localparam logic [79:0] VEC [10] = '{
        {64'h0000_0000_0000_0000, 2'd0, 7'd0,  7'd0},
        {64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 7'd0,  7'd0},
        {64'hA5A5_A5A5_5A5A_5A5A, 2'd1, 7'd3,  7'd0},
        {64'h0123_4567_89AB_CDEF, 2'd1, 7'd71, 7'd0},
        {64'hDEAD_BEEF_CAFE_F00D, 2'd1, 7'd64, 7'd0},
        {64'h0000_0000_0000_0001, 2'd1, 7'd0,  7'd0},
        {64'h8000_0000_0000_0000, 2'd2, 7'd3,  7'd5},
        {64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 7'd0,  7'd71},
        {64'h5555_5555_5555_5555, 2'd2, 7'd1,  7'd2},
        {64'h0F0F_0F0F_0F0F_0F0F, 2'd2, 7'd70, 7'd33}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [71:0] w;
        logic [71:0] exp_w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        check("R10 dec_valid", 72'(dec_valid), 72'd0);
        check("R10 flags", 72'({err_single, err_double}), 72'd0);
        check("R10 err_addr_valid", 72'(err_addr_valid), 72'd0);
        check("R10 err_addr", 72'(err_addr), 72'd0);
        check("R10 dec_data", 72'(dec_data), 72'd0);

        // Table walk: encode with injection, loop back, decode (R1 R2 R4 R5 R6 R7 R9)
        foreach (VEC[i]) begin
            logic [63:0] d;
            logic [1:0]  m;
            int pa, pb;
            d  = VEC[i][79:16];
            m  = VEC[i][15:14];
            pa = int'(VEC[i][13:7]);
            pb = int'(VEC[i][6:0]);
            @(negedge clk);
            enc_data   = d;
            inj_single = (m == 2'd1);
            inj_double = (m == 2'd2);
            inj_pos_a  = VEC[i][13:7];
            inj_pos_b  = VEC[i][6:0];
            #1;
            exp_w = ref_cw(d);
            if (m != 2'd0) exp_w ^= bit_at(pa);
            if (m == 2'd2) exp_w ^= bit_at(pb);
            check("R1/R6 enc_word", enc_word, exp_w);
            w = enc_word;
            do_read(w, AW'(16'h0100 + i), 1'b1);
            inj_single = 1'b0;
            inj_double = 1'b0;
            check("R7 dec_valid", 72'(dec_valid), 72'd1);
            check("R2/R4 err_single", 72'(err_single), 72'(m == 2'd1));
            check("R4 err_double", 72'(err_double), 72'(m == 2'd2));
            if (m == 2'd2)
                check("R4 raw data", 72'(dec_data), 72'(ref_data(exp_w)));
            else
                check("R2/R5 data", 72'(dec_data), 72'(d));
            check("R9 err_addr_valid", 72'(err_addr_valid), 72'(m != 2'd0));
            if (m != 2'd0) check("R9 err_addr", 72'(err_addr), 72'(16'h0100 + i));
        end

        // R6: out-of-range position inverts nothing
        @(negedge clk);
        enc_data   = 64'h1357_9BDF_2468_ACE0;
        inj_single = 1'b1;
        inj_pos_a  = 7'd100;
        #1;
        check("R6 pos>=72", enc_word, ref_cw(64'h1357_9BDF_2468_ACE0));
        inj_single = 1'b0;
        #1;
        check("R1 no inject", enc_word, ref_cw(64'h1357_9BDF_2468_ACE0));

        // R7: idle cycle after a read
        @(negedge clk);
        check("R7 idle dec_valid", 72'(dec_valid), 72'd0);
        check("R7 idle flags", 72'({err_single, err_double}), 72'd0);

        // R2 and R5: every single index corrected
        for (int p = 0; p < 72; p++) begin
            logic [63:0] d;
            d = 64'hC3A5_0F96_7E81_24DB ^ (64'(p) << 20);
            do_read(ref_cw(d) ^ bit_at(p), AW'(p), 1'b1);
            check("R2/R5 sweep data", 72'(dec_data), 72'(d));
            check("R2/R5 sweep flag", 72'({err_single, err_double}), 72'b10);
        end

        // R3: a stored faulty word is flagged again on a second read
        w = ref_cw(64'h0BAD_F00D_1234_5678) ^ bit_at(10);
        do_read(w, AW'(16'h0AAA), 1'b1);
        check("R3 first read flag", 72'(err_single), 72'd1);
        do_read(w, AW'(16'h0AAA), 1'b0);
        check("R3 second read flag", 72'(err_single), 72'd1);
        check("R3 second read data", 72'(dec_data), 72'(64'h0BAD_F00D_1234_5678));

        // R8: first error wins, later errors and clean reads leave it
        do_read(ref_cw(64'h11) ^ bit_at(5), AW'(16'h1111), 1'b1);
        do_read(ref_cw(64'h22) ^ bit_at(6) ^ bit_at(9), AW'(16'h2222), 1'b0);
        check("R8 held after 2nd error", 72'(err_addr), 72'(16'h1111));
        check("R8 flag of 2nd error", 72'(err_double), 72'd1);
        do_read(ref_cw(64'h33), AW'(16'h3333), 1'b0);
        check("R8 held after clean", 72'({err_addr_valid, err_addr}), 72'({1'b1, 16'h1111}));

        // R9: clear alone, then a new capture
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R9 cleared", 72'(err_addr_valid), 72'd0);
        do_read(ref_cw(64'h44) ^ bit_at(40), AW'(16'h4444), 1'b0);
        check("R9 recapture", 72'({err_addr_valid, err_addr}), 72'({1'b1, 16'h4444}));

        // R10: reset again clears the log and outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 re-reset log", 72'({err_addr_valid, err_addr}), 72'd0);
        check("R10 re-reset data", 72'(dec_data), 72'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule